// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt

This block is a register-mapped watchdog. Software loads a 16-bit tick count and sets a run bit. A prescaler divides the system clock down to the watchdog tick, which is 128 ms by default. Each tick removes one from the count. Software keeps the system alive by writing the count again before it runs out. Reading the count returns the number of ticks still remaining.

When the count reaches zero while the timer is running, the block does three things. It emits a single-cycle reset request, clears its own run bit and records the expiry in a status flag. A pre-timeout stage can also be enabled. It raises a sticky flag a fixed number of ticks before expiry; the default is 70 ticks, about 9 s. An enabled pre-timeout also drives a non-maskable interrupt request. Software clears the status flags by writing ones to them.

Top module: `wdog_nmi_timer`

## Requirements
- R1: After reset the count, control and status registers read 0, and both `nmi_req_o` and `rst_req_o` are low.
- R2: A write to offset 0x70 loads `wdata_i` into the count. A read of 0x70 returns the remaining count.
- R3: While control bit 0 (run) is 1, the count drops by one every `TICK_CYCLES` clock cycles. The first step comes `TICK_CYCLES` cycles after the write that set run. The count never goes below zero.
- R4: While run is 0, the count holds its value. Writing control with bit 0 cleared stops the timer, and the other control bits read back as written. Setting run again resumes the count from the held value.
- R5: If the count is 0 while run is 1, `rst_req_o` goes high in the next cycle for exactly one cycle. In that same cycle run clears, status bit 2 sets, and the count stays at 0.
- R6: Status bit 1 sets when control bit 2 is 1 and a tick takes the count from `PRE_TICKS`+1 down to `PRE_TICKS`. It stays clear when control bit 2 is 0. It also stays clear when the count was started at or below `PRE_TICKS`.
- R7: `nmi_req_o` is high exactly when control bit 2 is 1 and status bit 1 or status bit 2 is set.
- R8: A write to the status register at offset 0x6E clears each flag whose `wdata_i` bit is 1. Zero bits leave flags unchanged, and set flags stay set until cleared.
- R9: Status sits at 0x6E, count at 0x70 and control at 0x72. Reads at any other offset return 0, and writes there change nothing.
- R10: A count write while running restarts the tick phase. The next step comes `TICK_CYCLES` cycles after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register at `addr_i` |
| addr_i | input | 7 | Byte offset within the register window |
| wdata_i | input | 16 | Write data: 16 bits for the count, low 8 bits for status and control |
| rdata_o | output | 16 | Combinational read data for `addr_i` |
| nmi_req_o | output | 1 | Non-maskable interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `TICK_CYCLES` = 3 and `PRE_TICKS` = 2, so every countdown lasts only a few dozen cycles. With these values it sweeps start counts 0 through 8, each with pre-timeout both on and off. On every cycle it compares the count, the control and status registers and both request outputs with arithmetic predictions. The sweep covers start counts below, at and above the pre-timeout edge, including an immediate expiry from zero. Further runs check a restart of the tick phase by ping, a freeze and resume by stop, the write-one-to-clear rules and the unmapped offsets.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] OFF_STAT = 7'h6E;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 7'h70;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 7'h72;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_PRE = 2;
  localparam int unsigned ST_PRE   = 1;
  localparam int unsigned ST_EXP   = 2;
  localparam logic [7:0]  ST_MASK  = 8'h06;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned TICK_CYCLES = 12_800_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] phase_q;
  logic          wrap;

  assign wrap   = (phase_q == LAST);
  assign tick_o = run_i && !restart_i && wrap;

  // phase is held at zero while stopped so a start begins a full tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (!run_i || restart_i || wrap) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRE_TICKS = 70
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             pre_hit_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] PRE_EDGE = CNT_W'(PRE_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rst_req_q;
  logic             at_zero;

  assign at_zero   = (cnt_q == '0);
  assign expire_o  = run_i && at_zero && !load_i;
  assign pre_hit_o = tick_i && !load_i && (cnt_q == PRE_EDGE);
  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && !at_zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire_o;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  input  logic              pre_hit_i,
  output logic              cnt_load_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [7:0] ctrl_q;
  logic [7:0] status_q;
  logic       wr_stat, wr_ctrl;
  logic [7:0] st_set, st_clr;

  assign wr_stat    = wr_en_i && (addr_i == OFF_STAT);
  assign wr_ctrl    = wr_en_i && (addr_i == OFF_CTRL);
  assign cnt_load_o = wr_en_i && (addr_i == OFF_CNT);

  always_comb begin
    st_set         = '0;
    st_set[ST_PRE] = pre_hit_i && ctrl_q[CTRL_PRE];
    st_set[ST_EXP] = expire_i;
    st_clr         = wr_stat ? (wdata_i[7:0] & ST_MASK) : 8'h00;
  end

  // expiry overrides a coincident write of the run bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q <= wdata_i[7:0];
      if (expire_i) ctrl_q[CTRL_RUN] <= 1'b0;
    end
  end

  // new events win over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~st_clr) | st_set;
  end

  always_comb begin
    unique case (addr_i)
      OFF_STAT: rdata_o = DATA_W'(status_q);
      OFF_CNT:  rdata_o = DATA_W'(cnt_i);
      OFF_CTRL: rdata_o = DATA_W'(ctrl_q);
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
endmodule

// File: rtl/wdog_nmi_timer.sv
module wdog_nmi_timer
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 12_800_000,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRE_TICKS   = 70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              nmi_req_o,
  output logic              rst_req_o
);
  logic             tick;
  logic             cnt_load;
  logic             expire;
  logic             pre_hit;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       ctrl;
  logic [7:0]       status;

  wdog_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl[CTRL_RUN]),
    .restart_i (cnt_load),
    .tick_o    (tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .PRE_TICKS(PRE_TICKS)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl[CTRL_RUN]),
    .tick_i     (tick),
    .load_i     (cnt_load),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .cnt_o      (cnt),
    .expire_o   (expire),
    .pre_hit_o  (pre_hit),
    .rst_req_o  (rst_req_o)
  );

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .expire_i   (expire),
    .pre_hit_i  (pre_hit),
    .cnt_load_o (cnt_load),
    .ctrl_o     (ctrl),
    .status_o   (status),
    .rdata_o    (rdata_o)
  );

  assign nmi_req_o = ctrl[CTRL_PRE] && (status[ST_PRE] || status[ST_EXP]);
endmodule

// File: rtl/wdog_nmi_timer_chk.sv
module wdog_nmi_timer_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [7:0]        ctrl_i,
  input logic [7:0]        status_i,
  input logic              nmi_req_o,
  input logic              rst_req_o
);
  logic cnt_wr, stat_wr, ctrl_wr;
  assign cnt_wr  = wr_en_i && (addr_i == OFF_CNT);
  assign stat_wr = wr_en_i && (addr_i == OFF_STAT);
  assign ctrl_wr = wr_en_i && (addr_i == OFF_CTRL);

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt_i == $past(wdata_i[CNT_W-1:0])));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[CTRL_RUN] && !cnt_wr) |=>
      (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) - 1'b1));

  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[CTRL_RUN] && !cnt_wr) |=> $stable(cnt_i));

  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_expiry_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (cnt_i == '0 && !ctrl_i[CTRL_RUN] && status_i[ST_EXP]));

  assert_nmi_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req_o && !ctrl_wr && !stat_wr) |=> nmi_req_o);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[ST_PRE] && !(stat_wr && wdata_i[ST_PRE])) |=> status_i[ST_PRE]);
endmodule

bind wdog_nmi_timer wdog_nmi_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .cnt_i     (cnt),
  .ctrl_i    (ctrl),
  .status_i  (status),
  .nmi_req_o (nmi_req_o),
  .rst_req_o (rst_req_o)
);

// File: tb/wdog_nmi_timer_bench.sv
module wdog_nmi_timer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int T = 3;
  localparam int P = 2;
  localparam logic [6:0] A_ST = 7'h6E;
  localparam logic [6:0] A_CN = 7'h70;
  localparam logic [6:0] A_CT = 7'h72;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        nmi, rreq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_nmi_timer #(.TICK_CYCLES(T), .CNT_W(16), .PRE_TICKS(P)) u_wdog_nmi_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .nmi_req_o (nmi),
    .rst_req_o (rreq)
  );

  task automatic chk(string tag, int act, int e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, e);
    end
  endtask

  // called in the low phase; returns in the low phase after the write edge
  task automatic wr(logic [6:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output int v);
    addr = a;
    #0.2;
    v = int'(rdata);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, e, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CN, v); chk("R1 count", v, 0);
    rd(A_CT, v); chk("R1 ctrl", v, 0);
    rd(A_ST, v); chk("R1 status", v, 0);
    chk("R1 nmi", int'(nmi), 0);
    chk("R1 rst_req", int'(rreq), 0);

    // R2 load and read back while stopped
    wr(A_CN, 16'hBEEF);
    rd(A_CN, v); chk("R2 readback", v, 'hBEEF);

    // sweep of start counts and pre-timeout mode
    for (int n = 0; n <= 8; n++) begin
      for (int pe = 0; pe <= 1; pe++) begin
        wr(A_CN, 16'(n));
        wr(A_CT, pe ? 16'h0085 : 16'h0081);
        for (int k = 0; k <= n * T + 3; k++) begin
          int st;
          e = n - k / T; if (e < 0) e = 0;
          rd(A_CN, v); chk("R3 count", v, e);
          chk("R5 rst_req", int'(rreq), (k == n * T + 1) ? 1 : 0);
          st = ((pe == 1 && n > P && k >= (n - P) * T) ? 2 : 0) |
               ((k >= n * T + 1) ? 4 : 0);
          rd(A_ST, v); chk("R6 status", v, st);
          chk("R7 nmi", int'(nmi), (pe == 1 && st != 0) ? 1 : 0);
          rd(A_CT, v);
          chk("R5 ctrl", v, (pe ? 'h84 : 'h80) | ((k < n * T + 1) ? 1 : 0));
          @(negedge clk);
        end
        wr(A_ST, 16'h0000);
        rd(A_ST, v);
        chk("R8 zero write keeps", v, ((pe == 1 && n > P) ? 2 : 0) | 4);
        wr(A_ST, 16'h00FF);
        rd(A_ST, v); chk("R8 clear", v, 0);
      end
    end

    // R10 ping restarts count and tick phase
    wr(A_CN, 16'd10);
    wr(A_CT, 16'h0081);
    repeat (5) @(negedge clk);
    rd(A_CN, v); chk("R3 before ping", v, 10 - 5 / T);
    wr(A_CN, 16'd6);
    for (int m = 0; m <= 6 * T + 2; m++) begin
      e = 6 - m / T; if (e < 0) e = 0;
      rd(A_CN, v); chk("R10 count after ping", v, e);
      chk("R10 rst_req", int'(rreq), (m == 6 * T + 1) ? 1 : 0);
      @(negedge clk);
    end
    wr(A_ST, 16'h0006);

    // R4 stop freezes, keeps other bits, resume continues
    wr(A_CN, 16'd10);
    wr(A_CT, 16'h0085);
    repeat (4) @(negedge clk);
    wr(A_CT, 16'h0084);
    rd(A_CN, c0); chk("R4 value at stop", c0, 10 - 5 / T);
    repeat (10) @(negedge clk);
    rd(A_CN, v); chk("R4 frozen", v, c0);
    rd(A_CT, v); chk("R4 ctrl kept", v, 'h84);
    chk("R4 no reset", int'(rreq), 0);
    wr(A_CT, 16'h0085);
    repeat (T - 1) @(negedge clk);
    rd(A_CN, v); chk("R4 resume hold", v, c0);
    @(negedge clk);
    rd(A_CN, v); chk("R4 resume step", v, c0 - 1);
    wr(A_CT, 16'h0000);

    // R9 unmapped offsets
    wr(A_CN, 16'h1234);
    wr(7'h74, 16'hFFFF);
    wr(7'h71, 16'hFFFF);
    wr(7'h00, 16'hFFFF);
    rd(A_CN, v); chk("R9 count untouched", v, 'h1234);
    rd(A_CT, v); chk("R9 ctrl untouched", v, 0);
    rd(A_ST, v); chk("R9 status untouched", v, 0);
    rd(7'h74, v); chk("R9 unmapped read", v, 0);
    rd(7'h6C, v); chk("R9 unmapped read low", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule